// File: doc/BRIEF.md
# Cache maintenance broadcast controller

This block sits between a core's cache maintenance issue port and the request side of a coherent interconnect. Each maintenance operation arriving from the core is classified (instruction or data cache, by address or by set/way, invalidate, clean, clean-and-invalidate or zero). The controller combines that class with the target region's cacheability and shareability, a hypervisor force-broadcast control, the current security state and exception level, and three configuration straps captured while reset is held. From these it decides whether the operation runs on the local cache only or is also sent to the inner or outer shareable domain.

Every accepted operation is reported back to the core one cycle later, with a flag that says whether it was also broadcast. Broadcasts that the interconnect has accepted but not yet acknowledged are counted. A barrier request from the core holds off new maintenance work until that count reaches zero. If barrier broadcasting is strapped on, the controller then sends a barrier transaction and waits for its acknowledge. Only broadcasts issued by this core are waited on. Operations received from other cores never reach this block.

Top module: `cmo_bcast_ctrl`

## Requirements
- R1: Set/way operations (opcodes 5, 7, 10) and data zero by address (opcode 3) are never broadcast, whatever the region attributes.
- R2: Data invalidate by address and data clean-and-invalidate by address to the coherency point (opcodes 4, 9) are always broadcast. The domain is outer (ic_dom=1) when the region is cacheable and outer-shareable, and inner (ic_dom=0) otherwise.
- R3: Data clean by address to the coherency or unification point and instruction invalidate by address (opcodes 6, 8, 2) are broadcast only for a cacheable region. Shareability code 2'b11 sends them to the inner domain, 2'b10 to the outer domain, and 2'b00 or 2'b01 keeps them local.
- R4: Instruction invalidate-all for the inner shareable domain (opcode 0) is always broadcast to the inner domain.
- R5: Local instruction invalidate-all (opcode 1) and the EL1 TLB invalidate group (opcode 11) are broadcast to the inner domain only when force-broadcast is set, the core is Non-secure, and the exception level is 1. Otherwise they stay local.
- R6: For a non-cacheable region the shareability code is ignored. Opcodes 6, 8 and 2 stay local, and opcodes 4 and 9 go to the inner domain.
- R7: The inner, outer and barrier broadcast straps are captured only while reset is asserted. A broadcast aimed at a domain whose strap is off runs locally instead. Changing a strap after reset has no effect.
- R8: The outstanding count rises on each accepted broadcast and falls on each ic_ack. At CNT_MAX further broadcasts are held (req_ready=0, ic_valid=0) until an acknowledge frees a slot.
- R9: bar_done pulses only after the outstanding count has drained to zero. While a barrier is in progress, req_ready is 0 and ic_valid is 0.
- R10: With barrier broadcasting strapped on, ic_bar_valid rises after the drain and holds until ic_bar_ready. bar_done follows one cycle after ic_bar_ack. With it strapped off, no barrier transaction is issued.
- R11: Each accepted operation gives done_valid exactly one cycle later, with done_bcast showing whether it was broadcast. A local-only operation is accepted at once and raises no ic_valid.
- R12: After reset, the count is zero and ic_valid, ic_bar_valid, done_valid and bar_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_inner_bc | input | 1 | Strap: allow inner-domain broadcast (captured in reset) |
| cfg_outer_bc | input | 1 | Strap: allow outer-domain broadcast (captured in reset) |
| cfg_barrier_bc | input | 1 | Strap: allow barrier broadcast (captured in reset) |
| req_valid | input | 1 | Maintenance operation offered by the core |
| req_ready | output | 1 | Operation accepted this cycle when high with req_valid |
| req_op | input | 4 | Operation code |
| req_share | input | 2 | Region shareability: 00/01 none, 10 outer, 11 inner |
| req_cacheable | input | 1 | Region is normal cacheable |
| req_force_bc | input | 1 | Hypervisor force-broadcast control |
| req_nonsecure | input | 1 | Core runs in Non-secure state |
| req_el | input | 2 | Current exception level |
| done_valid | output | 1 | Operation accepted in the previous cycle |
| done_bcast | output | 1 | That operation was also broadcast |
| ic_valid | output | 1 | Broadcast request to the interconnect |
| ic_ready | input | 1 | Interconnect takes the broadcast |
| ic_op | output | 4 | Operation code of the broadcast |
| ic_dom | output | 1 | Broadcast domain: 0 inner, 1 outer |
| ic_ack | input | 1 | One broadcast completed |
| bar_req | input | 1 | Barrier requested by the core (held until bar_done) |
| bar_done | output | 1 | Barrier complete |
| ic_bar_valid | output | 1 | Barrier transaction to the interconnect |
| ic_bar_ready | input | 1 | Interconnect takes the barrier |
| ic_bar_ack | input | 1 | Barrier transaction completed |

## Verification
A wrong decode shows up in the same cycle as a wrong ic_valid or ic_dom while the request is offered, and as a wrong done_bcast one cycle later. A drifting outstanding count does not show up right away. It appears later, either as a broadcast stalled below the limit, or as a barrier that completes too early or never completes. For that reason the bench compares every output on every cycle against a behavioural model, saturates the counter, and drains barriers with broadcasts still pending. Captured straps are checked by changing the strap inputs after reset and confirming that the domain decision does not move.

// File: rtl/cmo_pkg.sv
// Shared encodings for the maintenance broadcast controller.
// Assumes opcodes outside the listed set are treated as local-only.
package cmo_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_I_INV_ALL_IS = 4'd0,
        OP_I_INV_ALL    = 4'd1,
        OP_I_INV_VA     = 4'd2,
        OP_D_ZERO_VA    = 4'd3,
        OP_D_INV_VA     = 4'd4,
        OP_D_INV_SW     = 4'd5,
        OP_D_CLN_VA     = 4'd6,
        OP_D_CLN_SW     = 4'd7,
        OP_D_CLN_VA_PU  = 4'd8,
        OP_D_CI_VA      = 4'd9,
        OP_D_CI_SW      = 4'd10,
        OP_TLB_INV_EL1  = 4'd11
    } cmo_op_e;

    localparam logic [1:0] SH_NONE  = 2'b00;
    localparam logic [1:0] SH_OUTER = 2'b10;
    localparam logic [1:0] SH_INNER = 2'b11;

    localparam logic DOM_INNER = 1'b0;
    localparam logic DOM_OUTER = 1'b1;

    typedef enum logic [2:0] {
        BS_IDLE  = 3'd0,
        BS_DRAIN = 3'd1,
        BS_SEND  = 3'd2,
        BS_WAIT  = 3'd3,
        BS_DONE  = 3'd4
    } bar_state_e;

endpackage

// File: rtl/cmo_bcast_decode.sv
// Broadcast decision for one maintenance operation.
// Purely combinational. Assumes the strap inputs are already the captured
// values. A domain whose strap is off falls back to local execution.
module cmo_bcast_decode
    import cmo_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic [1:0]      share,
    input  logic            cacheable,
    input  logic            force_bc,
    input  logic            nonsecure,
    input  logic [1:0]      el,
    input  logic            inner_en,
    input  logic            outer_en,
    output logic            bcast,
    output logic            dom
);

    logic want;
    logic shared_region;

    // Region is shareable in the sense that matters for conditional ops.
    assign shared_region = cacheable && (share == SH_OUTER || share == SH_INNER);

    // Classify the opcode into a broadcast wish and a target domain.
    always_comb begin
        want = 1'b0;
        dom  = DOM_INNER;
        case (op)
            OP_D_INV_VA, OP_D_CI_VA: begin
                want = 1'b1;
                dom  = (cacheable && share == SH_OUTER) ? DOM_OUTER : DOM_INNER;
            end
            OP_D_CLN_VA, OP_D_CLN_VA_PU, OP_I_INV_VA: begin
                want = shared_region;
                dom  = (share == SH_OUTER) ? DOM_OUTER : DOM_INNER;
            end
            OP_I_INV_ALL_IS: begin
                want = 1'b1;
            end
            OP_I_INV_ALL, OP_TLB_INV_EL1: begin
                want = force_bc && nonsecure && (el == 2'd1);
            end
            default: begin
                want = 1'b0;
            end
        endcase
    end

    // Straps gate the wish per domain.
    assign bcast = want && ((dom == DOM_OUTER) ? outer_en : inner_en);

endmodule

// File: rtl/cmo_pending_ctr.sv
// Counter of broadcasts issued but not yet acknowledged.
// Assumes inc is already suppressed when full and that the interconnect
// never acknowledges more than was issued. A stray ack at zero is dropped.
module cmo_pending_ctr #(
    parameter int CNT_MAX = 4,
    localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output logic             empty
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

    assign full  = (cnt == LIMIT);
    assign empty = (cnt == '0);

    // Track issued minus acknowledged broadcasts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (!full)  cnt <= cnt + 1'b1;
                2'b01:   if (!empty) cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R8: the count never passes its limit
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    // R8: an increment alone moves the count up by one
    p_inc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && !full) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/cmo_barrier_seq.sv
// Barrier sequencer. It waits for the outstanding count to drain, then
// optionally sends a barrier transaction and waits for its acknowledge.
// Assumes the core holds bar_req until bar_done and drops it right after.
module cmo_barrier_seq
    import cmo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bar_req,
    input  logic empty,
    input  logic bar_en,
    input  logic ic_bar_ready,
    input  logic ic_bar_ack,
    output logic busy,
    output logic ic_bar_valid,
    output logic bar_done
);

    bar_state_e state, nxt;

    // Next-state selection for the barrier sequence.
    always_comb begin
        nxt = state;
        case (state)
            BS_IDLE:  if (bar_req) nxt = BS_DRAIN;
            BS_DRAIN: if (empty)   nxt = bar_en ? BS_SEND : BS_DONE;
            BS_SEND:  if (ic_bar_ready) nxt = BS_WAIT;
            BS_WAIT:  if (ic_bar_ack)   nxt = BS_DONE;
            BS_DONE:  nxt = BS_IDLE;
            default:  nxt = BS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= BS_IDLE;
        else        state <= nxt;
    end

    assign busy         = (state != BS_IDLE);
    assign ic_bar_valid = (state == BS_SEND);
    assign bar_done     = (state == BS_DONE);

    // R10: an offered barrier stays offered until taken
    p_bar_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_bar_valid && !ic_bar_ready) |=> ic_bar_valid);

    // R10: with the barrier strap off no barrier transaction appears
    p_bar_strap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bar_en |-> !ic_bar_valid);

endmodule

// File: rtl/cmo_bcast_ctrl.sv
// Top level of the maintenance broadcast controller. It captures the straps
// during reset, decodes each request, forwards broadcasts to the
// interconnect, counts outstanding broadcasts and runs barriers.
// Assumes the core holds req_* stable while req_valid is high and not ready.
module cmo_bcast_ctrl
    import cmo_pkg::*;
#(
    parameter int CNT_MAX = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_inner_bc,
    input  logic            cfg_outer_bc,
    input  logic            cfg_barrier_bc,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [OP_W-1:0] req_op,
    input  logic [1:0]      req_share,
    input  logic            req_cacheable,
    input  logic            req_force_bc,
    input  logic            req_nonsecure,
    input  logic [1:0]      req_el,
    output logic            done_valid,
    output logic            done_bcast,
    output logic            ic_valid,
    input  logic            ic_ready,
    output logic [OP_W-1:0] ic_op,
    output logic            ic_dom,
    input  logic            ic_ack,
    input  logic            bar_req,
    output logic            bar_done,
    output logic            ic_bar_valid,
    input  logic            ic_bar_ready,
    input  logic            ic_bar_ack
);

    localparam int CNT_W = $clog2(CNT_MAX + 1);

    logic             s_inner, s_outer, s_bar;
    logic             bc, dom;
    logic             full, empty, busy;
    logic             acc, inc;
    logic [CNT_W-1:0] cnt;

    // Capture straps only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_inner <= cfg_inner_bc;
            s_outer <= cfg_outer_bc;
            s_bar   <= cfg_barrier_bc;
        end
    end

    cmo_bcast_decode u_dec (
        .op        (req_op),
        .share     (req_share),
        .cacheable (req_cacheable),
        .force_bc  (req_force_bc),
        .nonsecure (req_nonsecure),
        .el        (req_el),
        .inner_en  (s_inner),
        .outer_en  (s_outer),
        .bcast     (bc),
        .dom       (dom)
    );

    assign ic_valid  = req_valid && bc && !full && !busy;
    assign req_ready = !busy && (bc ? (ic_ready && !full) : 1'b1);
    assign acc       = req_valid && req_ready;
    assign inc       = ic_valid && ic_ready;
    assign ic_op     = req_op;
    assign ic_dom    = dom;

    cmo_pending_ctr #(.CNT_MAX(CNT_MAX)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .dec   (ic_ack),
        .cnt   (cnt),
        .full  (full),
        .empty (empty)
    );

    cmo_barrier_seq u_bar (
        .clk          (clk),
        .rst_n        (rst_n),
        .bar_req      (bar_req),
        .empty        (empty),
        .bar_en       (s_bar),
        .ic_bar_ready (ic_bar_ready),
        .ic_bar_ack   (ic_bar_ack),
        .busy         (busy),
        .ic_bar_valid (ic_bar_valid),
        .bar_done     (bar_done)
    );

    // Report each accepted operation one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_bcast <= 1'b0;
        end else begin
            done_valid <= acc;
            done_bcast <= acc && bc;
        end
    end

    // R11: every acceptance is reported in the next cycle
    p_accept_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> done_valid);

    // R8: no broadcast is offered while the counter is full
    p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !ic_valid);

    // R9: a barrier only completes with nothing outstanding
    p_bar_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |-> (cnt == '0));

    // R9: no maintenance is accepted while a barrier runs
    p_bar_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R1: set/way and zero operations never leave the core
    p_setway_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_D_INV_SW || req_op == OP_D_CLN_SW ||
         req_op == OP_D_CI_SW  || req_op == OP_D_ZERO_VA) |-> !ic_valid);

endmodule

// File: tb/tb_cmo_bcast_ctrl.sv
// Self-checking bench: a behavioural model is compared with every output on
// every falling edge. Stimulus changes just after rising edges.
module tb_cmo_bcast_ctrl;

    localparam int MAXC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_inner_bc = 1'b1, cfg_outer_bc = 1'b1, cfg_barrier_bc = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [3:0] req_op = 4'd0;
    logic [1:0] req_share = 2'b00, req_el = 2'd0;
    logic req_cacheable = 1'b1, req_force_bc = 1'b0, req_nonsecure = 1'b0;
    logic done_valid, done_bcast, ic_valid, ic_dom, bar_done, ic_bar_valid;
    logic [3:0] ic_op;
    logic ic_ready = 1'b1, ic_ack = 1'b0, bar_req = 1'b0;
    logic ic_bar_ready = 1'b0, ic_bar_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cmo_bcast_ctrl #(.CNT_MAX(MAXC)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_inner_bc(cfg_inner_bc), .cfg_outer_bc(cfg_outer_bc),
        .cfg_barrier_bc(cfg_barrier_bc),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_share(req_share), .req_cacheable(req_cacheable),
        .req_force_bc(req_force_bc), .req_nonsecure(req_nonsecure),
        .req_el(req_el), .done_valid(done_valid), .done_bcast(done_bcast),
        .ic_valid(ic_valid), .ic_ready(ic_ready), .ic_op(ic_op),
        .ic_dom(ic_dom), .ic_ack(ic_ack), .bar_req(bar_req),
        .bar_done(bar_done), .ic_bar_valid(ic_bar_valid),
        .ic_bar_ready(ic_bar_ready), .ic_bar_ack(ic_bar_ack)
    );

    task automatic chk(input logic act, input logic exp, input string tag,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t",
                     tag, what, act, exp, $time);
        end
    endtask

    // Requirement-level broadcast decision.
    function automatic void decide(input logic [3:0] op, input logic [1:0] sh,
        input logic cach, input logic frc, input logic ns, input logic [1:0] el,
        input logic en_i, input logic en_o,
        output logic bc, output logic dm, output string tag);
        logic w;
        w = 1'b0; dm = 1'b0; tag = "R11";
        case (op)
            4'd3, 4'd5, 4'd7, 4'd10: tag = "R1";
            4'd4, 4'd9: begin
                w = 1'b1; dm = (cach && sh == 2'b10);
                tag = cach ? "R2" : "R6";
            end
            4'd2, 4'd6, 4'd8: begin
                w = cach && sh[1]; dm = (sh == 2'b10);
                tag = cach ? "R3" : "R6";
            end
            4'd0: begin w = 1'b1; tag = "R4"; end
            4'd1, 4'd11: begin w = frc && ns && el == 2'd1; tag = "R5"; end
            default: tag = "R11";
        endcase
        bc = w && (dm ? en_o : en_i);
        if (w && !bc) tag = "R7";
    endfunction

    // Model state.
    int   m_cnt = 0;
    int   m_bs = 0;
    logic m_done = 1'b0, m_dbc = 1'b0;
    logic s_in = 1'b0, s_out = 1'b0, s_bar = 1'b0;
    logic post_reset = 1'b0;

    // Compare and advance the model once per cycle.
    always @(negedge clk) begin
        logic bc, dm, busy, full, e_icv, e_rdy, acc, inc;
        string tag, rtag;
        if (!rst_n) begin
            m_cnt = 0; m_bs = 0; m_done = 1'b0; m_dbc = 1'b0;
            s_in = cfg_inner_bc; s_out = cfg_outer_bc; s_bar = cfg_barrier_bc;
            post_reset = 1'b1;
        end else begin
            decide(req_op, req_share, req_cacheable, req_force_bc,
                   req_nonsecure, req_el, s_in, s_out, bc, dm, tag);
            busy  = (m_bs != 0);
            full  = (m_cnt == MAXC);
            e_icv = req_valid && bc && !full && !busy;
            e_rdy = !busy && (bc ? (ic_ready && !full) : 1'b1);
            rtag  = busy ? "R9" : ((bc && full) ? "R8" : tag);
            if (post_reset) begin
                chk(ic_valid, 1'b0, "R12", "ic_valid after reset");
                chk(done_valid, 1'b0, "R12", "done_valid after reset");
                chk(bar_done, 1'b0, "R12", "bar_done after reset");
                chk(ic_bar_valid, 1'b0, "R12", "ic_bar_valid after reset");
                post_reset = 1'b0;
            end
            if (req_valid) chk(req_ready, e_rdy, rtag, "req_ready");
            chk(ic_valid, e_icv, rtag, "ic_valid");
            if (e_icv && ic_valid) chk(ic_dom, dm, tag, "ic_dom");
            chk(done_valid, m_done, "R11", "done_valid");
            chk(done_bcast, m_dbc, "R11", "done_bcast");
            chk(ic_bar_valid, m_bs == 2, "R10", "ic_bar_valid");
            chk(bar_done, m_bs == 4, "R9", "bar_done");
            acc = req_valid && e_rdy;
            inc = e_icv && ic_ready;
            m_done = acc;
            m_dbc  = acc && bc;
            case (m_bs)
                0: if (bar_req) m_bs = 1;
                1: if (m_cnt == 0) m_bs = s_bar ? 2 : 4;
                2: if (ic_bar_ready) m_bs = 3;
                3: if (ic_bar_ack) m_bs = 4;
                default: m_bs = 0;
            endcase
            if (inc && !ic_ack) m_cnt++;
            else if (!inc && ic_ack && m_cnt > 0) m_cnt--;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic offer(input logic [3:0] op, input logic [1:0] sh,
                         input logic cach);
        req_op = op; req_share = sh; req_cacheable = cach; req_valid = 1'b1;
    endtask

    task automatic wait_acc;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic issue(input logic [3:0] op, input logic [1:0] sh,
                         input logic cach);
        offer(op, sh, cach);
        wait_acc();
        step(1);
    endtask

    task automatic acks(input int n);
        for (int i = 0; i < n; i++) begin
            ic_ack = 1'b1; step(1); ic_ack = 1'b0;
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0; step(3); rst_n = 1'b1; step(1);
    endtask

    initial begin
        step(1);
        do_reset();

        // R1: set/way and zero stay local even for shared regions
        issue(4'd5, 2'b11, 1'b1); issue(4'd7, 2'b10, 1'b1);
        issue(4'd10, 2'b11, 1'b1); issue(4'd3, 2'b10, 1'b1);
        // R2: always broadcast, domain from attributes
        issue(4'd4, 2'b00, 1'b1); issue(4'd9, 2'b10, 1'b1);
        issue(4'd4, 2'b11, 1'b1); acks(3);
        // R3: conditional on shareability
        issue(4'd6, 2'b00, 1'b1); issue(4'd6, 2'b11, 1'b1);
        issue(4'd8, 2'b10, 1'b1); issue(4'd2, 2'b01, 1'b1);
        issue(4'd2, 2'b11, 1'b1); acks(3);
        // R6: non-cacheable ignores shareability
        issue(4'd8, 2'b10, 1'b0); issue(4'd9, 2'b10, 1'b0); acks(1);
        // R4 and R5
        issue(4'd0, 2'b00, 1'b0);
        issue(4'd1, 2'b00, 1'b1);
        req_force_bc = 1'b1; req_nonsecure = 1'b1; req_el = 2'd1;
        issue(4'd1, 2'b00, 1'b1); issue(4'd11, 2'b00, 1'b1);
        req_nonsecure = 1'b0; issue(4'd11, 2'b00, 1'b1);
        req_nonsecure = 1'b1; req_el = 2'd2; issue(4'd1, 2'b00, 1'b1);
        req_force_bc = 1'b0; req_el = 2'd0;
        acks(3);

        // R8: saturate, then one ack frees a slot
        for (int i = 0; i < MAXC; i++) issue(4'd4, 2'b11, 1'b1);
        offer(4'd9, 2'b11, 1'b1); step(3);
        ic_ack = 1'b1; step(1); ic_ack = 1'b0;
        wait_acc(); step(1);
        // R8: interconnect not ready holds the request
        ic_ready = 1'b0; offer(4'd4, 2'b11, 1'b1); step(2);
        ic_ack = 1'b1; ic_ready = 1'b1; step(1); ic_ack = 1'b0;
        wait_acc(); step(1);
        acks(MAXC);

        // R9/R10: barrier with two broadcasts pending
        issue(4'd4, 2'b11, 1'b1); issue(4'd9, 2'b10, 1'b1);
        bar_req = 1'b1; step(2);
        offer(4'd5, 2'b00, 1'b1); step(3);
        acks(2);
        do @(negedge clk); while (!ic_bar_valid);
        step(2); ic_bar_ready = 1'b1; step(1); ic_bar_ready = 1'b0;
        step(1); ic_bar_ack = 1'b1; step(1); ic_bar_ack = 1'b0;
        do @(negedge clk); while (!bar_done);
        @(posedge clk); #1; bar_req = 1'b0;
        wait_acc(); step(2);

        // R7: outer and barrier straps off
        cfg_outer_bc = 1'b0; cfg_barrier_bc = 1'b0;
        do_reset();
        cfg_outer_bc = 1'b1; cfg_barrier_bc = 1'b1;
        issue(4'd4, 2'b10, 1'b1); issue(4'd6, 2'b10, 1'b1);
        issue(4'd4, 2'b11, 1'b1);
        bar_req = 1'b1; step(3);
        acks(1);
        do @(negedge clk); while (!bar_done);
        @(posedge clk); #1; bar_req = 1'b0; step(2);
        // R7: inner strap off
        cfg_inner_bc = 1'b0;
        do_reset();
        cfg_inner_bc = 1'b1;
        issue(4'd0, 2'b00, 1'b1); issue(4'd9, 2'b11, 1'b1);
        step(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        checks++; errors++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule